// File: doc/BRIEF.md
# Phase-Shifted Programmable Output Divider

This block turns a double-rate tick into a divided clock-like level. The source being divided runs at half the tick rate, so one source period spans two ticks and a divide value C gives an output period of 2C ticks. Working in ticks lets the output start half a source period early or late using only rising-edge logic.

A phase code selects a delay of the output waveform. Each delay is legal only with certain divide values. Two further angles come from the invert control combined with a legal shift: 45° inverted gives 225°, and 135° inverted gives 315°. Divide value, phase code and invert are captured while the synchronous reset is held and then stay fixed while the divider runs. An illegal pairing raises an error flag and the divider runs unshifted.

The block only produces a level for enable-style use. It does not generate real clocks and does not switch glitch-free between settings.

Top module: `ckdiv_phase`

## Requirements
- R1: With a divide value C from 1 to 256 and `en` high, `clk_out` repeats every 2C ticks.
- R2: For even C the output is high for C ticks and low for C ticks. For odd C above 1 it is high for C+1 ticks and low for C-1 ticks. For C = 1 it alternates high and low on every tick.
- R3: `phase_sel` codes are 0 = 0°, 1 = 45°, 2 = 90°, 3 = 135°, 4 = 180° and 5 = 270°. A legal shift delays the waveform by angle/360 × 2C ticks. With 0° the first enabled tick after reset drives the start of the high phase.
- R4: Legal pairs are code 0 with any C. C = 2 also allows codes 2, 4 and 5. C = 4 also allows codes 1, 2 and 3. C = 6 also allows code 2. A legal pair leaves `cfg_err` low.
- R5: Any other pair sets `cfg_err` and the output runs with 0° delay. Pairs that raise the error include codes 6 and 7, and a divide value of 0 or above 256; such a divide value runs as C = 1.
- R6: When `invert` is captured high, `clk_out` is the complement of the waveform it would otherwise show. This covers 225° and 315°.
- R7: Inputs are captured only on ticks where `srst` is high. Changes while `srst` is low have no effect on the output.
- R8: On a tick with `srst` high, `clk_out` goes low on that edge, whatever the value of `en`.
- R9: On a tick with `en` low and `srst` low, `clk_out` and the waveform position hold. When `en` returns high the sequence resumes where it stopped.
- R10: Asynchronous reset (`rst_n` low) drives `clk_out` low and `cfg_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-rate tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srst | input | 1 | Synchronous reset; captures the settings |
| en | input | 1 | Tick enable |
| div_val | input | 9 | Divide value C (legal range 1..256) |
| phase_sel | input | 3 | Phase code (0..5) |
| invert | input | 1 | Output complement control |
| clk_out | output | 1 | Divided, shifted output level |
| cfg_err | output | 1 | Illegal divide/phase pairing captured |

## Verification
The synchronous reset and the enable can both be high on the same tick. The bench keeps `en` high through every capture cycle, and the first output after release must show reset priority: low, with the waveform starting at the programmed offset. Capture and running also meet in one tick: on the tick after release the bench scrambles every setting input. Each later output is then compared with a sequence worked out from the captured settings alone, so any leak of the new inputs shows up as a mismatch.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

  localparam logic [2:0] PH_0   = 3'd0;
  localparam logic [2:0] PH_45  = 3'd1;
  localparam logic [2:0] PH_90  = 3'd2;
  localparam logic [2:0] PH_135 = 3'd3;
  localparam logic [2:0] PH_180 = 3'd4;
  localparam logic [2:0] PH_270 = 3'd5;

  // Angle of a phase code in units of 45 degrees (eighths of a period).
  function automatic logic [2:0] phase_eighths(input logic [2:0] code);
    logic [2:0] r;
    case (code)
      PH_45:   r = 3'd1;
      PH_90:   r = 3'd2;
      PH_135:  r = 3'd3;
      PH_180:  r = 3'd4;
      PH_270:  r = 3'd6;
      default: r = 3'd0;
    endcase
    return r;
  endfunction

  // Legality of a divide/phase pair.
  function automatic logic phase_legal(input int unsigned c, input logic [2:0] code);
    logic ok;
    ok = 1'b0;
    if (code == PH_0) ok = 1'b1;
    else begin
      case (c)
        2:       ok = (code == PH_90) || (code == PH_180) || (code == PH_270);
        4:       ok = (code == PH_45) || (code == PH_90) || (code == PH_135);
        6:       ok = (code == PH_90);
        default: ok = 1'b0;
      endcase
    end
    return ok;
  endfunction

endpackage

// File: rtl/ckdiv_cfg.sv
module ckdiv_cfg
  import ckdiv_pkg::*;
#(
  parameter int unsigned MAX_DIV = 256,
  parameter int unsigned DW      = $clog2(MAX_DIV + 1),
  parameter int unsigned PW      = $clog2(2 * MAX_DIV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic [DW-1:0] div_in,
  input  logic [2:0]    phase_in,
  input  logic          inv_in,
  output logic [PW-1:0] period_o,
  output logic [PW-1:0] high_o,
  output logic [PW-1:0] start_nx_o,
  output logic          inv_o,
  output logic          err_o
);

  logic          div_ok;
  logic [PW-1:0] c_eff;
  logic [PW-1:0] per_c;
  logic [PW-1:0] hi_c;
  logic          ph_ok;
  logic [2:0]    eighths;
  logic [PW+2:0] prod;
  logic [PW-1:0] delay;

  logic [PW-1:0] period_q, period_d;
  logic [PW-1:0] high_q,   high_d;
  logic          inv_q,    inv_d;
  logic          err_q,    err_d;

  // Decode of the live inputs
  always_comb begin
    div_ok  = (div_in >= DW'(1)) && (div_in <= DW'(MAX_DIV));
    c_eff   = div_ok ? PW'(div_in) : PW'(1);
    per_c   = c_eff << 1;
    if (c_eff == PW'(1))  hi_c = PW'(1);
    else if (c_eff[0])    hi_c = c_eff + PW'(1);
    else                  hi_c = c_eff;
    ph_ok   = phase_legal(int'(c_eff), phase_in);
    eighths = ph_ok ? phase_eighths(phase_in) : 3'd0;
    prod    = {3'b000, per_c} * {{PW{1'b0}}, eighths};
    delay   = prod[PW+2:3];
    start_nx_o = (delay == '0) ? '0 : (per_c - delay);
  end

  // Next state: capture only under synchronous reset
  always_comb begin
    period_d = period_q;
    high_d   = high_q;
    inv_d    = inv_q;
    err_d    = err_q;
    if (srst) begin
      period_d = per_c;
      high_d   = hi_c;
      inv_d    = inv_in;
      err_d    = !div_ok || !ph_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= PW'(2);
      high_q   <= PW'(1);
      inv_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      period_q <= period_d;
      high_q   <= high_d;
      inv_q    <= inv_d;
      err_q    <= err_d;
    end
  end

  assign period_o = period_q;
  assign high_o   = high_q;
  assign inv_o    = inv_q;
  assign err_o    = err_q;

  // R7: settings frozen outside synchronous reset
  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !srst |=> ($stable(period_o) && $stable(high_o) && $stable(inv_o) && $stable(err_o)));

  // R2: high time nonzero and within the period
  a_r2_high_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    (high_o != '0) && (high_o <= period_o));

endmodule

// File: rtl/ckdiv_gen.sv
module ckdiv_gen #(
  parameter int unsigned PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          en,
  input  logic [PW-1:0] start_i,
  input  logic [PW-1:0] period_i,
  input  logic [PW-1:0] high_i,
  input  logic          inv_i,
  output logic          out_o
);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          out_q, out_d;
  logic          last;

  always_comb begin
    last  = (cnt_q == period_i - PW'(1));
    cnt_d = cnt_q;
    out_d = out_q;
    if (srst) begin
      cnt_d = start_i;
      out_d = 1'b0;
    end else if (en) begin
      cnt_d = last ? '0 : cnt_q + PW'(1);
      out_d = (cnt_q < high_i) ^ inv_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign out_o = out_q;

  // R1: position stays inside the period
  a_r1_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < period_i);

  // R1: wrap at end of period
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && en && last) |=> (cnt_q == '0));

  // R8: synchronous reset wins over enable and forces output low
  a_r8_srst_low: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !out_o);

  // R9: disabled tick holds output and position
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && !en) |=> ($stable(out_o) && $stable(cnt_q)));

endmodule

// File: rtl/ckdiv_phase.sv
module ckdiv_phase #(
  parameter int unsigned MAX_DIV = 256,
  parameter int unsigned DW      = $clog2(MAX_DIV + 1),
  parameter int unsigned PW      = $clog2(2 * MAX_DIV + 1)
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          en,
  input  logic [DW-1:0] div_val,
  input  logic [2:0]    phase_sel,
  input  logic          invert,
  output logic          clk_out,
  output logic          cfg_err
);

  logic [PW-1:0] period_w;
  logic [PW-1:0] high_w;
  logic [PW-1:0] start_w;
  logic          inv_w;

  ckdiv_cfg #(.MAX_DIV(MAX_DIV), .DW(DW), .PW(PW)) u_cfg (
    .clk        (clk2x),
    .rst_n      (rst_n),
    .srst       (srst),
    .div_in     (div_val),
    .phase_in   (phase_sel),
    .inv_in     (invert),
    .period_o   (period_w),
    .high_o     (high_w),
    .start_nx_o (start_w),
    .inv_o      (inv_w),
    .err_o      (cfg_err)
  );

  ckdiv_gen #(.PW(PW)) u_gen (
    .clk      (clk2x),
    .rst_n    (rst_n),
    .srst     (srst),
    .en       (en),
    .start_i  (start_w),
    .period_i (period_w),
    .high_i   (high_w),
    .inv_i    (inv_w),
    .out_o    (clk_out)
  );

endmodule

// File: tb/tb_ckdiv_phase.sv
module tb_ckdiv_phase;

  localparam int CLK_PERIOD = 10;

  logic       clk2x = 1'b0;
  logic       rst_n = 1'b0;
  logic       srst = 1'b0;
  logic       en = 1'b0;
  logic [8:0] div_val = '0;
  logic [2:0] phase_sel = '0;
  logic       invert = 1'b0;
  logic       clk_out;
  logic       cfg_err;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  ckdiv_phase dut (
    .clk2x(clk2x), .rst_n(rst_n), .srst(srst), .en(en),
    .div_val(div_val), .phase_sel(phase_sel), .invert(invert),
    .clk_out(clk_out), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk2x = ~clk2x;

  always @(posedge clk2x) begin
    cyc <= cyc + 1;
    if (cyc >= 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit legal(input int c, input int code);
    if (code == 0) return 1'b1;
    if (c == 2 && (code == 2 || code == 4 || code == 5)) return 1'b1;
    if (c == 4 && (code == 1 || code == 2 || code == 3)) return 1'b1;
    if (c == 6 && code == 2) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int angle(input int code);
    case (code)
      1: return 45;  2: return 90;  3: return 135;
      4: return 180; 5: return 270;
      default: return 0;
    endcase
  endfunction

  function automatic int ceff(input int c);
    return (c < 1 || c > 256) ? 1 : c;
  endfunction

  function automatic bit exp_err(input int c, input int code);
    return (c < 1 || c > 256) || !legal(ceff(c), code);
  endfunction

  function automatic int exp_out(input int c, input int code, input int inv, input int k);
    int cc, p, d, hi, pos;
    cc = ceff(c);
    p  = 2 * cc;
    d  = exp_err(c, code) ? 0 : (angle(code) * p) / 360;
    hi = (cc == 1) ? 1 : ((cc % 2) ? cc + 1 : cc);
    pos = (k + p - d) % p;
    return ((pos < hi) ? 1 : 0) ^ inv;
  endfunction

  function automatic string tag_of(input int c, input int code, input int inv);
    if (exp_err(c, code)) return "R5";
    if (inv != 0)         return "R6";
    if (code != 0)        return "R3";
    return "R1 R2";
  endfunction

  // Capture settings, release, run; scramble inputs after release (R7)
  task automatic run_cfg(input int c, input int code, input int inv);
    int p;
    p = 2 * ceff(c);
    @(negedge clk2x);
    srst = 1'b1; en = 1'b1;
    div_val = 9'(c); phase_sel = 3'(code); invert = inv[0];
    @(negedge clk2x);
    chk("R8", int'(clk_out), 0);
    chk(exp_err(c, code) ? "R5" : "R4", int'(cfg_err), int'(exp_err(c, code)));
    srst = 1'b0;
    for (int k = 0; k < 2 * p + 3; k++) begin
      @(negedge clk2x);
      if (k == 0) begin
        div_val = 9'(c + 3); phase_sel = 3'(code + 1); invert = ~inv[0];
      end
      chk(k == 0 ? "R7" : tag_of(c, code, inv), int'(clk_out), exp_out(c, code, inv, k));
    end
  endtask

  initial begin
    int k;
    int held;
    repeat (3) @(negedge clk2x);
    chk("R10", int'(clk_out), 0);
    chk("R10", int'(cfg_err), 0);
    rst_n = 1'b1;

    // Sweep small divide values, every phase code, both polarities
    for (int c = 0; c <= 17; c++)
      for (int code = 0; code < 8; code++)
        for (int inv = 0; inv < 2; inv++)
          run_cfg(c, code, inv);

    // Top of range and just beyond
    for (int code = 0; code < 8; code += 3) begin
      run_cfg(255, code, 0);
      run_cfg(256, code, 1);
      run_cfg(257, code, 0);
    end

    // R9: enable gap mid-run, C = 4 at 45 degrees
    @(negedge clk2x);
    srst = 1'b1; en = 1'b1; div_val = 9'd4; phase_sel = 3'd1; invert = 1'b0;
    @(negedge clk2x);
    srst = 1'b0;
    k = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk2x);
      chk("R9", int'(clk_out), exp_out(4, 1, 0, k));
      k++;
    end
    held = int'(clk_out);
    en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk2x);
      chk("R9", int'(clk_out), held);
    end
    en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk2x);
      chk("R9", int'(clk_out), exp_out(4, 1, 0, k));
      k++;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule